// File: doc/BRIEF.md
# Single-Channel Word DMA with Buffer Reload

A single DMA channel that copies whole words from a source region to a destination region. For each word it issues a read request at the source address, then a write request of the returned data at the destination address. After every completed word both addresses advance by one word (4 bytes) and the byte count drops by 4. When the count reaches zero the channel raises a count-to-zero event. If a second buffer has been armed, the channel then copies a set of reload registers (source, destination, count) into its active registers and carries on in the next cycle, so two buffers run back to back with no gap on the memory port.

Software programs the channel through a flat word-addressed register port. It first writes the active addresses and count, and optionally the reload set. It then writes the control word carrying the start and reload-arm bits as the last step. While the channel runs, only the reload set may be changed. This lets an interrupt handler chain further buffers by refilling the reload registers and re-arming the reload bit, which clears itself each time it is consumed. A bus error or a timeout on the memory port stops the channel at once. One interrupt output reports count-to-zero events and channel stops. Each cause keeps a sticky status bit that software clears by writing 1 to it.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `mem_req_o` is 0.
- R2: Register offsets on `reg_addr_i` are 0 control, 1 status, 2 source, 3 destination, 4 count, 5 reload source, 6 reload destination and 7 reload count. Control bits are 0 start/running, 1 reload-arm, 2 count-zero interrupt enable, 3 stop interrupt enable and 4 interrupt output enable. A control write with bit 0 set starts an idle channel, and status bit 0 (running) then reads 1.
- R3: Each word is a read of the source address followed by a write of the returned data to the destination address. The request, address and direction stay stable until acknowledged. Each completed word adds 4 to both addresses and subtracts 4 from the count.
- R4: When the count reaches zero with reload-arm set, the active source, destination and count take the reload values. Status bits 2 (count-zero) and 3 (reloaded) are set, reload-arm clears, running stays 1, and the memory request does not drop between the two buffers.
- R5: When the count reaches zero with reload-arm clear, running goes to 0, count-zero status is set, reloaded status stays 0 and requests stop.
- R6: With control bit 2 set, every count-zero event sets interrupt-pending (status bit 1).
- R7: With control bit 3 set, every fall of running (completion, bus error or timeout) sets interrupt-pending.
- R8: A bus error or timeout on an outstanding request stops the channel at once with no reload. A bus error sets status bit 4. A timeout sets status bit 5 only when control bit 3 is set.
- R9: Writing 1 to any of status bits 2 to 5 clears those bits and interrupt-pending. Written 0s leave them unchanged.
- R10: If a cause bit is set in the same cycle as a write that clears it, the bit ends up set, and so does interrupt-pending.
- R11: `irq_o` is interrupt-pending gated by control bit 4.
- R12: Writes to the active source, destination and count are ignored while the channel runs. The reload registers accept writes at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Byte address of the request |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Request completed |
| mem_err_i | input | 1 | Request ended in bus error |
| mem_tmo_i | input | 1 | Request timed out |
| irq_o | output | 1 | Channel interrupt |

## Verification
The hardest case to reach from the ports is a clear write that lands in exactly the cycle a count-to-zero event sets the same cause bit. Memory latency is random, so that cycle cannot be predicted. The bench therefore holds a write of 1s to all cause bits on every cycle of a one-word transfer, watches the status readback each cycle, and releases the write in the cycle running is seen low. The count-zero bit and interrupt-pending must then read 1. Faults are injected after a chosen number of acknowledges, and reload arming is done from the bench while the first buffer is still running.

// File: rtl/dma_reload_pkg.sv
package dma_reload_pkg;
  localparam int unsigned REG_DW = 32;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_SRC  = 3'd2;
  localparam logic [2:0] RA_DST  = 3'd3;
  localparam logic [2:0] RA_CNT  = 3'd4;
  localparam logic [2:0] RA_RSRC = 3'd5;
  localparam logic [2:0] RA_RDST = 3'd6;
  localparam logic [2:0] RA_RCNT = 3'd7;

  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_RLD   = 1;
  localparam int unsigned CB_CTZIE = 2;
  localparam int unsigned CB_DISIE = 3;
  localparam int unsigned CB_IRQEN = 4;

  localparam int unsigned SB_RUN  = 0;
  localparam int unsigned SB_PEND = 1;
  localparam int unsigned SB_CZ0  = 2;  // first of four W1C cause bits
  localparam int unsigned N_CAUSE = 4;  // ctz, reload, bus error, timeout

  typedef struct packed {
    logic irq_en;
    logic dis_ie;
    logic ctz_ie;
    logic rld_en;
  } ctrl_t;

  typedef enum logic [1:0] {XS_IDLE, XS_RD, XS_WR} xfer_state_e;
endpackage

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_reload_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          last_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  input  logic          mem_tmo_i,
  output logic          word_done_o,
  output logic          bus_err_ev_o,
  output logic          tmo_ev_o,
  output logic          fault_o
);
  xfer_state_e state_q, state_d;
  logic [DW-1:0] data_q;

  assign mem_req_o    = (state_q != XS_IDLE);
  assign mem_we_o     = (state_q == XS_WR);
  assign mem_addr_o   = mem_we_o ? dst_i : src_i;
  assign mem_wdata_o  = data_q;
  assign fault_o      = mem_req_o & (mem_err_i | mem_tmo_i);
  assign bus_err_ev_o = mem_req_o & mem_err_i;
  assign tmo_ev_o     = mem_req_o & mem_tmo_i & ~mem_err_i;
  assign word_done_o  = (state_q == XS_WR) & mem_ack_i & ~fault_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE: if (run_i) state_d = XS_RD;
      XS_RD: begin
        if (fault_o)        state_d = XS_IDLE;
        else if (mem_ack_i) state_d = XS_WR;
      end
      XS_WR: begin
        if (fault_o)        state_d = XS_IDLE;
        else if (mem_ack_i) state_d = last_i ? XS_IDLE : XS_RD;
      end
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == XS_RD && mem_ack_i && !fault_o) data_q <= mem_rdata_i;
    end
  end

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !mem_err_i && !mem_tmo_i)
    |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_fault_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !mem_req_o);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_reload_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 16,
  parameter int unsigned STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  input  logic              word_done_i,
  input  logic              fault_i,
  output logic              ch_st_o,
  output ctrl_t             ctrl_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [CW-1:0]     cnt_o,
  output logic [AW-1:0]     rsrc_o,
  output logic [AW-1:0]     rdst_o,
  output logic [CW-1:0]     rcnt_o,
  output logic              last_o,
  output logic              ctz_ev_o,
  output logic              rld_ev_o,
  output logic              stop_ev_o
);
  logic ch_st_q;
  ctrl_t ctrl_q;
  logic [AW-1:0] src_q, dst_q, rsrc_q, rdst_q;
  logic [CW-1:0] cnt_q, rcnt_q;
  logic is_last, done_ev, wr_ctrl, wr_active;

  assign is_last   = (cnt_q <= CW'(STEP));
  assign ctz_ev_o  = word_done_i & is_last;
  assign rld_ev_o  = ctz_ev_o & ctrl_q.rld_en;
  assign done_ev   = ctz_ev_o & ~ctrl_q.rld_en;
  assign stop_ev_o = ch_st_q & (done_ev | fault_i);
  assign last_o    = is_last & ~ctrl_q.rld_en;
  assign wr_ctrl   = reg_we_i && reg_addr_i == RA_CTRL;
  assign wr_active = reg_we_i && !ch_st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_st_q <= 1'b0;
      ctrl_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      rsrc_q  <= '0;
      rdst_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      if (stop_ev_o)                           ch_st_q <= 1'b0;
      else if (wr_ctrl && reg_wdata_i[CB_RUN]) ch_st_q <= 1'b1;

      // a software write to control wins over the self-clear of reload-arm
      if (wr_ctrl) begin
        ctrl_q.rld_en <= reg_wdata_i[CB_RLD];
        ctrl_q.ctz_ie <= reg_wdata_i[CB_CTZIE];
        ctrl_q.dis_ie <= reg_wdata_i[CB_DISIE];
        ctrl_q.irq_en <= reg_wdata_i[CB_IRQEN];
      end else if (rld_ev_o) begin
        ctrl_q.rld_en <= 1'b0;
      end

      if (rld_ev_o) begin
        src_q <= rsrc_q;
        dst_q <= rdst_q;
        cnt_q <= rcnt_q;
      end else if (word_done_i) begin
        src_q <= src_q + AW'(STEP);
        dst_q <= dst_q + AW'(STEP);
        cnt_q <= cnt_q - CW'(STEP);
      end else if (wr_active) begin
        if (reg_addr_i == RA_SRC) src_q <= reg_wdata_i[AW-1:0];
        if (reg_addr_i == RA_DST) dst_q <= reg_wdata_i[AW-1:0];
        if (reg_addr_i == RA_CNT) cnt_q <= reg_wdata_i[CW-1:0];
      end

      if (reg_we_i && reg_addr_i == RA_RSRC) rsrc_q <= reg_wdata_i[AW-1:0];
      if (reg_we_i && reg_addr_i == RA_RDST) rdst_q <= reg_wdata_i[AW-1:0];
      if (reg_we_i && reg_addr_i == RA_RCNT) rcnt_q <= reg_wdata_i[CW-1:0];
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  assign ch_st_o = ch_st_q;
  assign ctrl_o  = ctrl_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cnt_o   = cnt_q;
  assign rsrc_o  = rsrc_q;
  assign rdst_o  = rdst_q;
  assign rcnt_o  = rcnt_q;

  p_reload_copy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_ev_o && !wr_ctrl) |=> (ch_st_q && cnt_q == $past(rcnt_q)
                                && src_q == $past(rsrc_q) && !ctrl_q.rld_en));

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_st_q && done_ev) |=> !ch_st_q);

  p_active_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_st_q && !word_done_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_reload_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stat_wr_i,
  input  logic [N_CAUSE-1:0] clr_i,
  input  logic               ctz_ev_i,
  input  logic               rld_ev_i,
  input  logic               bus_err_ev_i,
  input  logic               tmo_ev_i,
  input  logic               stop_ev_i,
  input  ctrl_t              ctrl_i,
  output logic [N_CAUSE-1:0] cause_o,
  output logic               ipend_o,
  output logic               irq_o
);
  logic [N_CAUSE-1:0] cause_q, set_vec, clr_vec;
  logic ipend_q, pend_set;

  assign set_vec  = {tmo_ev_i & ctrl_i.dis_ie, bus_err_ev_i, rld_ev_i, ctz_ev_i};
  assign clr_vec  = stat_wr_i ? clr_i : '0;
  assign pend_set = (ctz_ev_i & ctrl_i.ctz_ie) | (stop_ev_i & ctrl_i.dis_ie);

  for (genvar i = 0; i < N_CAUSE; i++) begin : g_cause
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q[i] <= 1'b0;
      else         cause_q[i] <= set_vec[i] | (cause_q[i] & ~clr_vec[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ipend_q <= 1'b0;
    else         ipend_q <= pend_set | (ipend_q & ~(|clr_vec));
  end

  assign cause_o = cause_q;
  assign ipend_o = ipend_q;
  assign irq_o   = ipend_q & ctrl_i.irq_en;

  p_ctz_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctz_ev_i && ctrl_i.ctz_ie) |=> ipend_q);

  p_stop_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ev_i && ctrl_i.dis_ie) |=> ipend_q);

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctz_ev_i && clr_vec[0]) |=> cause_q[0]);

  p_tmo_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.dis_ie && !cause_q[3]) |=> !cause_q[3]);
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
  import dma_reload_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic              mem_tmo_i,
  output logic              irq_o
);
  localparam int unsigned STEP = DW / 8;

  logic ch_st, last, word_done, fault, bus_err_ev, tmo_ev;
  logic ctz_ev, rld_ev, stop_ev, ipend;
  ctrl_t ctrl;
  logic [AW-1:0] src, dst, rsrc, rdst;
  logic [CW-1:0] cnt, rcnt;
  logic [N_CAUSE-1:0] cause;

  dma_chan_regs #(.AW(AW), .CW(CW), .STEP(STEP)) i_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .word_done_i(word_done), .fault_i(fault),
    .ch_st_o(ch_st), .ctrl_o(ctrl),
    .src_o(src), .dst_o(dst), .cnt_o(cnt),
    .rsrc_o(rsrc), .rdst_o(rdst), .rcnt_o(rcnt),
    .last_o(last), .ctz_ev_o(ctz_ev), .rld_ev_o(rld_ev), .stop_ev_o(stop_ev)
  );

  dma_xfer_fsm #(.AW(AW), .DW(DW)) i_fsm (
    .clk_i, .rst_ni, .run_i(ch_st), .last_i(last),
    .src_i(src), .dst_i(dst),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_rdata_i, .mem_ack_i, .mem_err_i, .mem_tmo_i,
    .word_done_o(word_done), .bus_err_ev_o(bus_err_ev),
    .tmo_ev_o(tmo_ev), .fault_o(fault)
  );

  dma_irq_ctrl i_irq (
    .clk_i, .rst_ni,
    .stat_wr_i(reg_we_i && reg_addr_i == RA_STAT),
    .clr_i(reg_wdata_i[SB_CZ0 +: N_CAUSE]),
    .ctz_ev_i(ctz_ev), .rld_ev_i(rld_ev), .bus_err_ev_i(bus_err_ev),
    .tmo_ev_i(tmo_ev), .stop_ev_i(stop_ev), .ctrl_i(ctrl),
    .cause_o(cause), .ipend_o(ipend), .irq_o
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CTRL: reg_rdata_o = REG_DW'({ctrl.irq_en, ctrl.dis_ie, ctrl.ctz_ie, ctrl.rld_en, ch_st});
      RA_STAT: reg_rdata_o = REG_DW'({cause, ipend, ch_st});
      RA_SRC:  reg_rdata_o = REG_DW'(src);
      RA_DST:  reg_rdata_o = REG_DW'(dst);
      RA_CNT:  reg_rdata_o = REG_DW'(cnt);
      RA_RSRC: reg_rdata_o = REG_DW'(rsrc);
      RA_RDST: reg_rdata_o = REG_DW'(rdst);
      RA_RCNT: reg_rdata_o = REG_DW'(rcnt);
      default: reg_rdata_o = '0;
    endcase
  end

  p_run_needs_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ch_st && !mem_req_o) |=> !mem_req_o || ch_st);
endmodule

// File: tb/test_dma_reload_chan.sv
`timescale 1ns/1ps
module test_dma_reload_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0, mem_tmo = 1'b0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  int checks = 0, fails = 0;
  logic [31:0] mem [256];
  logic [31:0] em  [256];
  int lat = 0, max_lat = 2, inj_cnt = 0, falls = 0;
  bit busy_gap = 0, inj_err = 0, inj_tmo = 0, prev_req = 0;

  always #4 clk = ~clk;

  dma_reload_chan i_dma_reload_chan (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .mem_tmo_i(mem_tmo), .irq_o(irq));

  // memory responder and request-fall monitor
  always @(negedge clk) begin
    mem_ack = 0; mem_err = 0; mem_tmo = 0;
    if (prev_req && !mem_req) falls++;
    prev_req = mem_req;
    if (busy_gap) busy_gap = 0;
    else if (rst_n && mem_req) begin
      if (lat > 0) lat--;
      else begin
        busy_gap = 1;
        lat = $urandom_range(max_lat, 0);
        if ((inj_err || inj_tmo) && inj_cnt == 0) begin
          if (inj_err) mem_err = 1; else mem_tmo = 1;
          inj_err = 0; inj_tmo = 0;
        end else begin
          mem_ack = 1;
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
          else mem_rdata = mem[mem_addr[9:2]];
          if (inj_cnt > 0) inj_cnt--;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd1, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] waddr(input int idx);
    return 32'(idx) << 2;
  endfunction

  task automatic exp_copy(input int s, input int d, input int n);
    for (int k = 0; k < n; k++) em[d + k] = em[s + k];
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== em[i]) bad++;
    check(bad == 0, req, 32'(bad), 32'd0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20251));
    for (int i = 0; i < 256; i++) begin mem[i] = $urandom; em[i] = mem[i]; end

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3'd0, d); check(d == 0, "R1 ctrl", d, 0);
    rd(3'd1, d); check(d == 0, "R1 stat", d, 0);
    check(irq == 0 && mem_req == 0, "R1 irq/req", {30'd0, irq, mem_req}, 0);

    // R2 R12 active registers writable while idle
    wr(3'd2, waddr(4)); wr(3'd3, waddr(130)); wr(3'd4, 32'd12);
    rd(3'd2, d); check(d == waddr(4), "R2 src readback", d, waddr(4));
    rd(3'd4, d); check(d == 12, "R12 cnt readback idle", d, 12);

    // R3 R5 R6 R11 single buffer, 3 words, ctz_ie + irq_en
    falls = 0;
    wr(3'd0, 32'h15);
    rd(3'd1, d); check(d[0] == 1, "R2 running after start", d, 1);
    wait_idle();
    exp_copy(4, 130, 3);
    check_mem("R3 data copy");
    rd(3'd2, d); check(d == waddr(7), "R3 src advanced", d, waddr(7));
    rd(3'd3, d); check(d == waddr(133), "R3 dst advanced", d, waddr(133));
    rd(3'd4, d); check(d == 0, "R3 cnt zero", d, 0);
    rd(3'd1, d); check(d[5:0] == 6'b000110, "R5 R6 stat after done", d, 32'h6);
    check(irq == 1, "R11 irq with enable", irq, 1);
    check(mem_req == 0, "R5 requests stopped", mem_req, 0);

    // R9 W1C
    wr(3'd1, 32'h0);
    rd(3'd1, d); check(d[2:1] == 2'b11, "R9 zero write no effect", d, 32'h6);
    wr(3'd1, 32'h4);
    rd(3'd1, d); check(d[5:1] == 0, "R9 clear ctz and pend", d, 0);
    check(irq == 0, "R11 irq cleared", irq, 0);

    // R4 R7 R12 chained: arm reload while first buffer runs
    wr(3'd2, waddr(10)); wr(3'd3, waddr(140)); wr(3'd4, 32'd16);
    falls = 0;
    wr(3'd0, 32'h09);                       // start, stop-irq enable
    wr(3'd2, 32'hDEAD0);                    // ignored while running (R12)
    wr(3'd5, waddr(70)); wr(3'd6, waddr(200)); wr(3'd7, 32'd12);
    wr(3'd0, 32'h0B);                       // arm reload
    for (int i = 0; i < 3000; i++) begin rd(3'd1, d); if (d[3]) break; end
    check(d[0] == 1 && d[2] == 1, "R4 still running after reload", d, 32'hD);
    rd(3'd0, d); check(d[1] == 0, "R4 reload-arm self-clear", d, 32'h9);
    rd(3'd6, d); check(d == waddr(200), "R12 reload writable", d, waddr(200));
    wait_idle();
    exp_copy(10, 140, 4); exp_copy(70, 200, 3);
    check_mem("R4 both buffers");
    rd(3'd2, d); check(d == waddr(73), "R12 active src unaffected", d, waddr(73));
    check(falls == 1, "R4 no gap between buffers", 32'(falls), 1);
    rd(3'd1, d); check(d[5:0] == 6'b001110, "R7 pend on completion", d, 32'hE);
    wr(3'd1, 32'h3C);

    // R8 bus error on third request, reload armed but not taken
    wr(3'd2, waddr(20)); wr(3'd3, waddr(150)); wr(3'd4, 32'd16);
    inj_err = 1; inj_cnt = 2;
    wr(3'd0, 32'h0B);
    wait_idle();
    exp_copy(20, 150, 1);
    check_mem("R8 partial copy");
    rd(3'd1, d); check(d[5:0] == 6'b010010, "R8 R7 bus error stat", d, 32'h12);
    rd(3'd4, d); check(d == 12, "R8 no reload cnt", d, 12);
    rd(3'd0, d); check(d[1] == 1, "R8 reload-arm kept", d, 32'hA);
    check(irq == 0, "R11 irq gated off", irq, 1'b0);
    wr(3'd1, 32'h3C);

    // R8 timeout with stop-irq disabled: not reported
    wr(3'd2, waddr(30)); wr(3'd3, waddr(160)); wr(3'd4, 32'd8);
    inj_tmo = 1; inj_cnt = 0;
    wr(3'd0, 32'h01);
    wait_idle();
    rd(3'd1, d); check(d[5:0] == 0, "R8 timeout hidden", d, 0);
    wr(3'd4, 32'd8);
    inj_tmo = 1; inj_cnt = 0;
    wr(3'd0, 32'h19);
    wait_idle();
    rd(3'd1, d); check(d[5:0] == 6'b100010, "R8 R7 timeout reported", d, 32'h22);
    check(irq == 1, "R11 irq on timeout", irq, 1);
    wr(3'd1, 32'h3C);

    // R10 clear write held through the count-zero cycle
    wr(3'd2, waddr(40)); wr(3'd3, waddr(170)); wr(3'd4, 32'd4);
    wr(3'd0, 32'h05);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); reg_we = 1; reg_addr = 3'd1; reg_wdata = 32'h3C;
      #1 d = reg_rdata;
      if (!d[0]) break;
    end
    reg_we = 0;
    check(d[2] == 1 && d[1] == 1, "R10 set wins over clear", d, 32'h6);
    exp_copy(40, 170, 1);
    wr(3'd1, 32'h3C);

    // random runs, R3 R4 R5
    for (int r = 0; r < 20; r++) begin
      int n1, n2, s1, d1, s2, d2;
      bit rl;
      n1 = $urandom_range(6, 1); n2 = $urandom_range(6, 1);
      s1 = $urandom_range(63 - n1, 0);  d1 = 128 + $urandom_range(63 - n1, 0);
      s2 = 64 + $urandom_range(63 - n2, 0); d2 = 192 + $urandom_range(63 - n2, 0);
      rl = $urandom_range(1, 0) == 1;
      max_lat = $urandom_range(3, 0);
      wr(3'd2, waddr(s1)); wr(3'd3, waddr(d1)); wr(3'd4, 32'(n1 * 4));
      wr(3'd5, waddr(s2)); wr(3'd6, waddr(d2)); wr(3'd7, 32'(n2 * 4));
      wr(3'd0, rl ? 32'h03 : 32'h01);
      wait_idle();
      exp_copy(s1, d1, n1);
      if (rl) exp_copy(s2, d2, n2);
      check_mem(rl ? "R4 random chained" : "R3 random single");
      rd(3'd2, d);
      check(d == (rl ? waddr(s2 + n2) : waddr(s1 + n1)), "R3 random final src", d,
            rl ? waddr(s2 + n2) : waddr(s1 + n1));
      rd(3'd1, d);
      check(d[3:0] == {rl, 3'b100}, "R5 random stat", d, {28'd0, rl, 3'b100});
      wr(3'd1, 32'h3C);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule